// File: doc/BRIEF.md
# Counted-Burst SPI Master

This block is a register-driven SPI master aimed at simple serial-flash reads. Software pushes command bytes into a 64-byte transmit queue, programs a total burst length and a transmit length, and then sets an exchange bit. The controller runs the whole burst with chip select held low. The first bytes it shifts out come from the transmit queue, and the remaining bytes are zero filler. Every byte clocked in during the burst is stored in a 64-byte receive queue, including the bytes received while the command went out.

A typical flash read uses a transmit length of 4 (opcode plus three address bytes) and a total of 4 plus the data length. Software drops the first four received bytes. With 64-entry queues, one burst returns at most 60 data bytes. A divider sets the serial clock, so a divider value of 1 turns a 24 MHz system clock into 6 MHz. Further controls are enable and master bits, a flush bit for each queue, and a soft reset that clears itself. A status word reports both queue levels.

The register port is a plain strobe bus with no back-pressure. A write is taken on the cycle it is strobed. Read data is registered and valid on the cycle after the read strobe. A write to a full transmit queue is dropped. A read from an empty receive queue returns zero and changes nothing.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the control word reads 0 and the status word reads 0.
- R2: Word addresses are 0 control, 1 divider, 2 total length, 3 transmit length, 4 status, 5 transmit push and 6 receive pop. Writing address 5 queues bits [7:0]. Reading address 6 returns the oldest received byte in bits [7:0] and removes it. Read data appears on the cycle after the read strobe.
- R3: Control bits are: bit 0 enable, bit 1 master, bit 2 transmit flush, bit 3 receive flush, bit 4 exchange and bit 31 soft reset. The status word holds the receive level in bits [6:0] and the transmit level in bits [14:8].
- R4: The serial clock idles low and has a period of 2*(divider+1) system cycles during a burst.
- R5: Data moves MSB first in mode 0. MOSI changes only at the falling serial-clock edge and never while the serial clock is high.
- R6: The first transmit-length bytes of a burst are taken from the transmit queue in order. All later bytes are 0x00. A byte due from an empty transmit queue is also sent as 0x00.
- R7: Every byte of the burst, command bytes included, enters the receive queue in the order it was clocked.
- R8: Chip select stays low without a break for the whole burst. It rises no earlier than one serial-clock period after the last falling edge. The exchange bit reads 0 once chip select has risen.
- R9: A request to set the exchange bit is ignored unless the same write also sets enable and master. In that case the exchange bit reads 0 and chip select stays high.
- R10: Writing 1 to a flush bit empties that queue. The flush bits always read back as 0.
- R11: Soft reset clears enable, master and exchange, empties both queues and ends any burst with chip select high. The bit then reads 0 again on a later poll.
- R12: A 64-byte burst fills the receive queue, and the status word then reports a receive level of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench goes after the boundary where the transmit phase hands over to zero filler. A design that miscounts there sends a stray command byte or loses one, and so it corrupts the flash address. It checks that the command bytes echo into the receive queue, because a design that skips them shifts all returned data by four. It drives a full 64-byte burst, where a level counter that is too narrow wraps to zero. It aborts a slow burst with soft reset, where a design that does not stop the engine leaves chip select low. It also sets the exchange bit without enable, which a careless design would start, and it measures the chip-select release gap, which a design that drops chip select on the last edge would cut short.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_DIV   = 3'd1;
  localparam logic [2:0] ADR_TOTAL = 3'd2;
  localparam logic [2:0] ADR_XMIT  = 3'd3;
  localparam logic [2:0] ADR_STAT  = 3'd4;
  localparam logic [2:0] ADR_TXQ   = 3'd5;
  localparam logic [2:0] ADR_RXQ   = 3'd6;

  localparam int BIT_EN   = 0;
  localparam int BIT_MST  = 1;
  localparam int BIT_TXFL = 2;
  localparam int BIT_RXFL = 3;
  localparam int BIT_XCH  = 4;
  localparam int BIT_SRST = 31;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_TAIL} eng_state_t;
endpackage

// File: rtl/sbm_fifo.sv
module sbm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (level == LW'(DEPTH)));
  assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

// File: rtl/sbm_engine.sv
module sbm_engine
  import sbm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] xmit,
  input  logic [7:0]       tx_data,
  input  logic             tx_empty,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso
);
  eng_state_t       state;
  logic [DIV_W-1:0] tick_cnt, div_q;
  logic [CNT_W-1:0] left, xleft, xsrc;
  logic [7:0]       sh, rsh, nxt_byte;
  logic [2:0]       bitcnt;
  logic             sclk_q, cs_q, tail_q;
  logic             tick, byte_end, begin_burst, load, use_tx;

  always_comb begin
    xsrc        = (state == ENG_IDLE) ? xmit : xleft;
    use_tx      = (xsrc != '0) && !tx_empty;
    nxt_byte    = use_tx ? tx_data : 8'h00;
    tick        = (tick_cnt == div_q);
    byte_end    = (state == ENG_SHIFT) && tick && sclk_q && (bitcnt == 3'd7);
    begin_burst = (state == ENG_IDLE) && start && (total != '0);
    load        = begin_burst || (byte_end && (left != CNT_W'(1)));
    tx_pop      = !abort && load && use_tx;
    rx_push     = !abort && byte_end;
    done        = !abort && (((state == ENG_IDLE) && start && (total == '0)) ||
                             ((state == ENG_TAIL) && tick && tail_q));
  end

  assign rx_data = rsh;
  assign busy    = (state != ENG_IDLE);
  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign mosi    = cs_q ? 1'b0 : sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE; tick_cnt <= '0; div_q <= '0; left <= '0; xleft <= '0;
      sh <= '0; rsh <= '0; bitcnt <= '0; sclk_q <= 1'b0; cs_q <= 1'b1; tail_q <= 1'b0;
    end else if (abort) begin
      state <= ENG_IDLE; sclk_q <= 1'b0; cs_q <= 1'b1; tick_cnt <= '0; tail_q <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: if (begin_burst) begin
          state    <= ENG_SHIFT;
          cs_q     <= 1'b0;
          sclk_q   <= 1'b0;
          sh       <= nxt_byte;
          bitcnt   <= '0;
          left     <= total;
          xleft    <= (xmit != '0) ? xmit - 1'b1 : '0;
          tick_cnt <= '0;
          div_q    <= div;
        end
        ENG_SHIFT: begin
          tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rsh    <= {rsh[6:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (bitcnt == 3'd7) begin
                if (left == CNT_W'(1)) begin
                  state  <= ENG_TAIL;
                  tail_q <= 1'b0;
                end else begin
                  sh     <= nxt_byte;
                  bitcnt <= '0;
                  left   <= left - 1'b1;
                  xleft  <= (xleft != '0) ? xleft - 1'b1 : '0;
                end
              end else begin
                sh     <= {sh[6:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
        end
        ENG_TAIL: begin
          tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
          if (tick) begin
            if (tail_q) begin
              state <= ENG_IDLE;
              cs_q  <= 1'b1;
            end else begin
              tail_q <= 1'b1;
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R4: the serial clock is low whenever chip select is released
  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q);
  // R5: data out holds still across the high phase
  assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi));
  // R7: a captured byte is pushed on the falling edge
  assert_push_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !sclk_q);
  // R8: the burst ends with chip select high after the done pulse
  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cs_q);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import sbm_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 8,
  parameter int DIV_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic             en_q, mst_q, xch_q, srst_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] total_q, xmit_q;
  logic             ctrl_wr, tx_flush, rx_flush, start;
  logic             tx_push, tx_pop, tx_empty, tx_full;
  logic             rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]       tx_dout, rx_din, rx_dout;
  logic [LW-1:0]    tx_level, rx_level;
  logic             busy, done;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata, tx_full, rx_full};

  assign ctrl_wr  = bus_wr && (bus_addr == ADR_CTRL);
  assign tx_flush = srst_q || (ctrl_wr && bus_wdata[BIT_TXFL]);
  assign rx_flush = srst_q || (ctrl_wr && bus_wdata[BIT_RXFL]);
  assign tx_push  = bus_wr && (bus_addr == ADR_TXQ);
  assign rx_pop   = bus_rd && (bus_addr == ADR_RXQ);
  assign start    = xch_q && !busy && !srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mst_q <= 1'b0; xch_q <= 1'b0; srst_q <= 1'b0;
      div_q <= '0; total_q <= '0; xmit_q <= '0;
    end else if (srst_q) begin
      en_q <= 1'b0; mst_q <= 1'b0; xch_q <= 1'b0; srst_q <= 1'b0;
    end else begin
      if (done) xch_q <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          ADR_CTRL: begin
            en_q   <= bus_wdata[BIT_EN];
            mst_q  <= bus_wdata[BIT_MST];
            srst_q <= bus_wdata[BIT_SRST];
            if (bus_wdata[BIT_XCH] && bus_wdata[BIT_EN] && bus_wdata[BIT_MST])
              xch_q <= 1'b1;
          end
          ADR_DIV:   div_q   <= bus_wdata[DIV_W-1:0];
          ADR_TOTAL: total_q <= bus_wdata[CNT_W-1:0];
          ADR_XMIT:  xmit_q  <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADR_CTRL: begin
        rd_mux[BIT_EN]   = en_q;
        rd_mux[BIT_MST]  = mst_q;
        rd_mux[BIT_XCH]  = xch_q;
        rd_mux[BIT_SRST] = srst_q;
      end
      ADR_DIV:   rd_mux = 32'(div_q);
      ADR_TOTAL: rd_mux = 32'(total_q);
      ADR_XMIT:  rd_mux = 32'(xmit_q);
      ADR_STAT:  rd_mux = 32'(rx_level) | (32'(tx_level) << 8);
      ADR_RXQ:   rd_mux = rx_empty ? 32'd0 : 32'(rx_dout);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  sbm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_dout),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  sbm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  sbm_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(srst_q), .start(start),
    .div(div_q), .total(total_q), .xmit(xmit_q),
    .tx_data(tx_dout), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_din), .busy(busy), .done(done),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n), .miso(spi_miso)
  );

  assert_srst_selfclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
  assert_xch_clear_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xch_q) |-> spi_cs_n);
  assert_xch_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xch_q) |-> (en_q && mst_q));
endmodule

// File: tb/test_spi_burst_master.sv
`timescale 1ns/1ps
module test_spi_burst_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;

  int checks = 0, failures = 0, seed = 0;
  bit finished = 0;
  int cyc = 0, csfall = 0, csrise = 0, nrise = 0;
  int last_rise = 0, last_fall = 0, per_min = 0, per_max = 0, gap = 0;
  bit have_rise = 0;
  int rk = 0, rb = 7, mb = 0, mi = 0, mosi_bad = 0;
  logic [7:0] msh = '0;
  logic [7:0] mosi_cap [0:127];
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;

  always #2.5 clk = ~clk;

  spi_burst_master i_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  function automatic logic [7:0] resp(input int k);
    return 8'(seed + k * 37);
  endfunction
  function automatic logic resp_bit(input int k, input int b);
    logic [7:0] v;
    v = resp(k);
    return v[b];
  endfunction

  always @(posedge clk) cyc++;

  // slave model: first bit valid at chip-select fall, advance on falling clock
  always @(negedge spi_cs_n) begin
    csfall++; rk = 0; rb = 7; mb = 0; mi = 0; have_rise = 0;
    spi_miso = resp_bit(0, 7);
  end
  always @(posedge spi_cs_n) begin csrise++; gap = cyc - last_fall; end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    last_fall = cyc;
    if (rb == 0) begin rk++; rb = 7; end else rb--;
    spi_miso = resp_bit(rk, rb);
  end
  always @(posedge spi_sclk) begin
    nrise++;
    if (have_rise) begin
      if (per_min == 0 || cyc - last_rise < per_min) per_min = cyc - last_rise;
      if (cyc - last_rise > per_max) per_max = cyc - last_rise;
    end
    last_rise = cyc; have_rise = 1;
    msh = {msh[6:0], spi_mosi}; mb++;
    if (mb == 8) begin mosi_cap[mi] = msh; mi++; mb = 0; end
  end
  always @(negedge clk) begin
    if (spi_sclk && prev_sclk && (spi_mosi != prev_mosi)) mosi_bad++;
    prev_sclk = spi_sclk; prev_mosi = spi_mosi;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_xch_clear(input string req);
    logic [31:0] d;
    d = 32'h10;
    for (int i = 0; i < 3000 && d[4]; i++) rd(3'd0, d);
    chk(req, {31'd0, d[4]}, 32'd0, "exchange bit after burst");
  endtask

  task automatic run_burst(input int total, input int xmit, input int div);
    per_min = 0; per_max = 0;
    wr(3'd1, div); wr(3'd2, total); wr(3'd3, xmit);
    wr(3'd0, 32'h13);
    wait_xch_clear("R8");
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", {30'd0, spi_cs_n, spi_sclk}, 32'h2, "idle pins cs_n,sclk");
    rd(3'd0, d); chk("R1", d, 0, "control after reset");
    rd(3'd4, d); chk("R1", d, 0, "status after reset");
  endtask

  task automatic t_flash_read();
    logic [31:0] d;
    int f0, r0;
    logic [7:0] cmd [4];
    cmd = '{8'h03, 8'h12, 8'h34, 8'h56};
    seed = 8'h5A;
    for (int i = 0; i < 4; i++) wr(3'd5, cmd[i]);
    f0 = csfall; r0 = nrise;
    run_burst(12, 4, 1);
    chk("R8", csfall - f0, 1, "single chip-select assertion");
    chk("R4", nrise - r0, 96, "serial clock rising edges");
    chk("R4", per_min, 4, "min period div=1");
    chk("R4", per_max, 4, "max period div=1");
    chk("R8", {31'd0, gap >= 4}, 1, "release gap at least one period");
    chk("R5", mosi_bad, 0, "MOSI changes while clock high");
    for (int i = 0; i < 12; i++)
      chk("R6", mosi_cap[i], (i < 4) ? cmd[i] : 8'h00, $sformatf("MOSI byte %0d", i));
    rd(3'd4, d); chk("R3", d, 12, "status after 12-byte burst");
    for (int i = 0; i < 12; i++) begin
      rd(3'd6, d); chk("R7", d, resp(i), $sformatf("RX byte %0d", i));
    end
    rd(3'd4, d); chk("R2", d, 0, "RX pops drain queue");
  endtask

  task automatic t_divider_empty_tx();
    logic [31:0] d;
    seed = 8'h11;
    run_burst(2, 2, 3);
    chk("R4", per_min, 8, "min period div=3");
    chk("R4", per_max, 8, "max period div=3");
    chk("R6", mosi_cap[0], 0, "empty queue byte 0 is zero");
    chk("R6", mosi_cap[1], 0, "empty queue byte 1 is zero");
    rd(3'd6, d); chk("R7", d, resp(0), "RX byte 0 div=3");
    rd(3'd6, d); chk("R7", d, resp(1), "RX byte 1 div=3");
  endtask

  task automatic t_gate();
    logic [31:0] d;
    int f0;
    f0 = csfall;
    wr(3'd2, 4); wr(3'd0, 32'h10);
    repeat (40) @(negedge clk);
    rd(3'd0, d); chk("R9", d, 0, "exchange without enable/master");
    wr(3'd0, 32'h11);
    repeat (40) @(negedge clk);
    rd(3'd0, d); chk("R9", d, 1, "exchange with enable only");
    wr(3'd0, 32'h12);
    repeat (40) @(negedge clk);
    rd(3'd0, d); chk("R9", d, 2, "exchange with master only");
    chk("R9", csfall - f0, 0, "no chip-select activity");
    wr(3'd0, 0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) wr(3'd5, 8'hA0 + i);
    rd(3'd4, d); chk("R3", d, 32'h300, "TX level field");
    wr(3'd0, 32'h4);
    rd(3'd4, d); chk("R10", d, 0, "TX flush empties");
    rd(3'd0, d); chk("R10", d, 0, "flush bits read 0");
    seed = 8'h33;
    run_burst(2, 0, 0);
    rd(3'd4, d); chk("R3", d, 2, "RX level field");
    wr(3'd0, 32'h8);
    rd(3'd4, d); chk("R10", d, 0, "RX flush empties");
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(3'd5, 8'h77); wr(3'd5, 8'h88);
    wr(3'd1, 20); wr(3'd2, 10); wr(3'd3, 1);
    wr(3'd0, 32'h13);
    repeat (200) @(negedge clk);
    chk("R11", {31'd0, spi_cs_n}, 0, "burst in progress before soft reset");
    wr(3'd0, 32'h8000_0000);
    d = 32'h8000_0000;
    for (int i = 0; i < 20 && d[31]; i++) rd(3'd0, d);
    chk("R11", d, 0, "control after soft reset");
    @(negedge clk);
    chk("R11", {30'd0, spi_cs_n, spi_sclk}, 32'h2, "pins after soft reset");
    rd(3'd4, d); chk("R11", d, 0, "queues after soft reset");
  endtask

  task automatic t_full();
    logic [31:0] d;
    seed = 8'hC3;
    for (int i = 0; i < 4; i++) wr(3'd5, 8'h03 + i);
    run_burst(64, 4, 0);
    rd(3'd4, d); chk("R12", d, 64, "RX level after 64-byte burst");
    for (int i = 0; i < 64; i++) begin
      rd(3'd6, d);
      if (i == 0 || i == 4 || i == 63) chk("R12", d, resp(i), $sformatf("RX byte %0d", i));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_flash_read();
    t_divider_empty_tx();
    t_gate();
    t_flush();
    t_srst();
    t_full();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule